// File: doc/BRIEF.md
# Wormhole Flit Switch

This block is a single-stage packet switch with several input and output ports. Packets travel as a run of fixed-width flits. The first flit of a packet names a destination, and the low bits of that destination pick the output port. From that point on, the output belongs to the input until the packet's last flit has gone downstream. Every later flit of the packet follows on that output as soon as it arrives. No whole packet is ever stored.

Each input keeps exactly one flit in a holding register. If the output a packet is using stops accepting, that output's holding register stays full and the input stops taking flits. The worm then stalls in place, back to its source. Packets bound for other outputs carry on unaffected. When several inputs with a new packet want the same free output, a round-robin arbiter for that output picks one. The others keep their head flit and wait.

Every data port uses a valid/ready handshake, and a flit moves in a cycle only when both are high. A sender must hold its valid and its flit steady until ready is seen. The switch follows the same rule on its outputs. The switch keeps nothing from a stalled downstream, and it only lowers `in_ready` when the holding register is full and will not empty in that cycle. The port count must be a power of two.

Top module: `wh_switch`

## Requirements
- R1: While reset is high, and in the cycle after it, every `out_valid` bit is 0 and every `in_ready` bit is 1. After reset, the round-robin pointer of every output is at input 0.
- R2: A packet-opening flit whose destination field is d leaves on output d mod NPORT, the low log2(NPORT) bits of the destination. No other output carries it, and the flit comes out unchanged.
- R3: The body and tail flits of a packet leave on the output its head took, in order, with all bits unchanged.
- R4: Once an output has granted a head, it carries flits of only that input until the tail flit has been accepted downstream. Heads from other inputs that want that output wait without being lost.
- R5: A single-flit packet does not reserve its output after it leaves. One input can push back-to-back single-flit packets through one output at one flit per cycle.
- R6: Among inputs that present a head for the same free output in the same cycle, the grant goes to the first requester at or after the pointer, searching upward and wrapping around. After a grant, the pointer moves to the input just after the winner.
- R7: Once `out_valid` is high on an output with `out_ready` low, the next cycle still shows `out_valid` high and the same flit.
- R8: Each input holds at most one flit. After an input accepts a flit, if no output accepts anything in the next cycle, that input's `in_ready` is 0.
- R9: A stalled output stops only the inputs that hold or want it. A packet from another input to a different output passes through during the stall.
- R10: Flit layout, from the most significant bit down, is: kind (2 bits), destination (DEST_W bits), payload (PAY_W bits). The kind codes are 2'b01 for a head, 2'b00 for a body, 2'b10 for a tail, and 2'b11 for a single-flit packet. Bit 0 of the kind marks a packet's first flit, and bit 1 marks its last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORT | Per-input flit offered |
| in_ready | output | NPORT | Per-input holding register can take a flit this cycle |
| in_flit | input | NPORT*(2+DEST_W+PAY_W) | Per-input flit, layout as in R10 |
| out_valid | output | NPORT | Per-output flit presented |
| out_ready | input | NPORT | Per-output downstream accepts the flit |
| out_flit | output | NPORT*(2+DEST_W+PAY_W) | Per-output flit |

## Verification
The hardest case to reach from the ports is a locked output whose downstream is stalled while a second head waits for that same output. Another packet must cross the switch to a different output at the same time. The stimulus gets there by releasing two inputs into the same free output in one cycle, and a third input toward a different output, while one `out_ready` bit is held low. It then checks how many flits each input has taken, what the stalled output is holding, and the order in which the waiting worms drain once ready returns. A sweep of every source against every destination covers routing. A four-way collision after reset fixes the expected round-robin order.

// File: rtl/wh_pkg.sv
package wh_pkg;
  // Flit kind codes; bit 0 opens a packet, bit 1 closes it.
  typedef enum logic [1:0] {
    KIND_BODY = 2'b00,
    KIND_HEAD = 2'b01,
    KIND_TAIL = 2'b10,
    KIND_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(input logic [1:0] kind);
    return kind[0];
  endfunction

  function automatic logic kind_closes(input logic [1:0] kind);
    return kind[1];
  endfunction
endpackage

// File: rtl/wh_in_buf.sv
// One-flit holding register in front of each input.
module wh_in_buf #(
  parameter int FLIT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              pop,
  output logic              hold_vld,
  output logic [FLIT_W-1:0] hold_flit
);
  // A full slot can still take a flit in the cycle it drains.
  assign in_ready = !hold_vld || pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_flit <= '0;
    end else if (in_valid && in_ready) begin
      hold_vld  <= 1'b1;
      hold_flit <= in_flit;
    end else if (pop) begin
      hold_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/wh_rr_arb.sv
// Round-robin pick among requesters; the pointer moves past the winner when take is high.
module wh_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!gnt_any && req[j]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (take && gnt_any) begin
      ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
    end
  end
endmodule

// File: rtl/wh_out_port.sv
// One output: arbitration while free, lock to the owner from grant until tail leaves.
module wh_out_port #(
  parameter int NPORT  = 4,
  parameter int FLIT_W = 13,
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             head_req,
  input  logic [NPORT-1:0]             hold_vld,
  input  logic [NPORT-1:0][FLIT_W-1:0] hold_flit,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [FLIT_W-1:0]            out_flit,
  output logic [NPORT-1:0]             pop_mask
);
  import wh_pkg::*;

  logic          busy;
  logic [IW-1:0] owner;
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;
  logic [IW-1:0] sel;
  logic          fire;
  logic          last;

  wh_rr_arb #(.N(NPORT)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (head_req),
    .take    (!busy),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  assign sel       = busy ? owner : gnt_idx;
  assign out_valid = busy ? hold_vld[owner] : gnt_any;
  assign out_flit  = hold_flit[sel];
  assign fire      = out_valid && out_ready;
  assign last      = kind_closes(out_flit[FLIT_W-1 -: 2]);

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      pop_mask[i] = fire && (sel == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= '0;
    end else begin
      if (busy) begin
        busy <= !(fire && last);
      end else begin
        busy  <= gnt_any && !(fire && last);
        owner <= gnt_idx;
      end
    end
  end
endmodule

// File: rtl/wh_switch.sv
// Wormhole flit switch, NPORT inputs by NPORT outputs.
module wh_switch #(
  parameter int NPORT  = 4,
  parameter int DEST_W = 3,
  parameter int PAY_W  = 8,
  localparam int FLIT_W = 2 + DEST_W + PAY_W,
  localparam int PSEL   = $clog2(NPORT)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             in_valid,
  output logic [NPORT-1:0]             in_ready,
  input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]             out_valid,
  input  logic [NPORT-1:0]             out_ready,
  output logic [NPORT-1:0][FLIT_W-1:0] out_flit
);
  import wh_pkg::*;

  logic [NPORT-1:0]             hold_vld;
  logic [NPORT-1:0][FLIT_W-1:0] hold_flit;
  logic [NPORT-1:0]             in_pop;
  // Indexed [output][input].
  logic [NPORT-1:0][NPORT-1:0]  head_req;
  logic [NPORT-1:0][NPORT-1:0]  pop_mask;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    wh_in_buf #(.FLIT_W(FLIT_W)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid[i]),
      .in_ready  (in_ready[i]),
      .in_flit   (in_flit[i]),
      .pop       (in_pop[i]),
      .hold_vld  (hold_vld[i]),
      .hold_flit (hold_flit[i])
    );
  end

  // Destination decode: a held opening flit requests the output named by its low dest bits.
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        head_req[o][i] = hold_vld[i]
                      && kind_opens(hold_flit[i][FLIT_W-1 -: 2])
                      && (hold_flit[i][PAY_W +: PSEL] == PSEL'(o));
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    wh_out_port #(.NPORT(NPORT), .FLIT_W(FLIT_W)) u_port (
      .clk       (clk),
      .rst       (rst),
      .head_req  (head_req[o]),
      .hold_vld  (hold_vld),
      .hold_flit (hold_flit),
      .out_valid (out_valid[o]),
      .out_ready (out_ready[o]),
      .out_flit  (out_flit[o]),
      .pop_mask  (pop_mask[o])
    );
  end

  always_comb begin
    in_pop = '0;
    for (int o = 0; o < NPORT; o++) begin
      in_pop = in_pop | pop_mask[o];
    end
  end
endmodule

// File: rtl/wh_switch_chk.sv
// Port-level protocol checker, bound into the switch.
module wh_switch_chk #(
  parameter int NPORT  = 4,
  parameter int DEST_W = 3,
  parameter int PAY_W  = 8,
  localparam int FLIT_W = 2 + DEST_W + PAY_W,
  localparam int PSEL   = $clog2(NPORT)
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPORT-1:0]             in_valid,
  input logic [NPORT-1:0]             in_ready,
  input logic [NPORT-1:0]             out_valid,
  input logic [NPORT-1:0]             out_ready,
  input logic [NPORT-1:0][FLIT_W-1:0] out_flit
);
  // Tracks, per output, whether a packet has opened and not yet closed downstream.
  logic [NPORT-1:0] mid_pkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_pkt <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          if (out_flit[o][FLIT_W-1]) mid_pkt[o] <= 1'b0;
          else if (out_flit[o][FLIT_W-2]) mid_pkt[o] <= 1'b1;
        end
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && in_ready == '1));

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    a_r2_head_route: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && out_flit[o][FLIT_W-2]) |-> (out_flit[o][PAY_W +: PSEL] == PSEL'(o)));

    a_r4_no_head_inside: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && mid_pkt[o]) |-> !out_flit[o][FLIT_W-2]);

    a_r3_first_opens: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !mid_pkt[o]) |-> out_flit[o][FLIT_W-2]);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o])));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    a_r8_single_slot: assert property (@(posedge clk) disable iff (rst)
      (out_ready == '0 && $past(in_valid[i] && in_ready[i])) |-> !in_ready[i]);
  end
endmodule

bind wh_switch wh_switch_chk #(.NPORT(NPORT), .DEST_W(DEST_W), .PAY_W(PAY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit)
);

// File: tb/test_wh_switch.sv
module test_wh_switch;
  localparam int N  = 4;
  localparam int DW = 3;
  localparam int PW = 8;
  localparam int FW = 2 + DW + PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0]         in_valid, in_ready, out_valid, out_ready;
  logic [N-1:0][FW-1:0] in_flit, out_flit;

  wh_switch #(.NPORT(N), .DEST_W(DW), .PAY_W(PW)) i_wh_switch (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [FW-1:0] src_q [N][16];
  int            src_len [N];
  int            src_idx [N];
  logic [FW-1:0] log_f [N][64];
  int            log_n [N];
  logic [N-1:0]  rdy_mask;
  logic [N-1:0]  hs_in;
  logic [N-1:0]  pv, pr;
  logic [N-1:0][FW-1:0] pf;

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input int d, input int p);
    return {k, DW'(d), PW'(p)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < N; i++) begin
      src_len[i] = 0; src_idx[i] = 0; log_n[i] = 0;
    end
    hs_in = '0; pv = '0; pr = '0; pf = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = '0; in_flit = '0; out_ready = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_stim();
  endtask

  // One cycle: drive at the falling edge, sample 1 ns later, log what the next rising edge moves.
  task automatic step();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (hs_in[i]) src_idx[i]++;
      in_valid[i] = (src_idx[i] < src_len[i]);
      in_flit[i]  = in_valid[i] ? src_q[i][src_idx[i]] : '0;
    end
    out_ready = rdy_mask;
    #1;
    hs_in = in_valid & in_ready;
    for (int o = 0; o < N; o++) begin
      if (pv[o] && !pr[o])
        chk(out_valid[o] && out_flit[o] == pf[o], "R7", int'(out_flit[o]), int'(pf[o]));
      if (out_valid[o] && out_ready[o]) begin
        log_f[o][log_n[o]] = out_flit[o];
        log_n[o]++;
      end
    end
    pv = out_valid; pr = out_ready; pf = out_flit;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = '0; in_flit = '0; out_ready = '0; rdy_mask = '1;
    clear_stim();
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == '0, "R1", int'(out_valid), 0);
    chk(in_ready == '1, "R1", int'(in_ready), 15);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(out_valid == '0 && in_ready == '1, "R1", int'({out_valid, in_ready}), 15);

    // R2/R10 sweep: every source against every destination with single-flit packets.
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < 8; d++) begin
        logic [FW-1:0] f;
        int others;
        clear_stim();
        f = mk(2'b11, d, s * 16 + d + 1);
        src_q[s][0] = f; src_len[s] = 1;
        rdy_mask = '1;
        repeat (4) step();
        others = 0;
        for (int o = 0; o < N; o++) if (o != d % N) others += log_n[o];
        chk(log_n[d % N] == 1 && log_f[d % N][0] == f, "R2", int'(log_f[d % N][0]), int'(f));
        chk(others == 0, "R10", others, 0);
      end
    end

    // R5: back-to-back single-flit packets through one output.
    clear_stim();
    for (int k = 0; k < 3; k++) src_q[0][k] = mk(2'b11, 5, 40 + k);
    src_len[0] = 3;
    repeat (4) step();
    chk(log_n[1] == 3, "R5", log_n[1], 3);
    for (int k = 0; k < 3; k++)
      chk(log_f[1][k] == mk(2'b11, 5, 40 + k), "R5", int'(log_f[1][k]), int'(mk(2'b11, 5, 40 + k)));

    // R3/R4/R6: four inputs collide on output 1 right after reset.
    do_reset();
    for (int i = 0; i < N; i++) begin
      src_q[i][0] = mk(2'b01, 1, i * 16);
      src_q[i][1] = mk(2'b00, 0, i * 16 + 1);
      src_q[i][2] = mk(2'b10, 0, i * 16 + 2);
      src_len[i] = 3;
    end
    rdy_mask = '1;
    repeat (20) step();
    chk(log_n[1] == 12, "R4", log_n[1], 12);
    for (int k = 0; k < 12; k++) begin
      int p, j;
      logic [FW-1:0] e;
      p = k / 3; j = k % 3;
      e = (j == 0) ? mk(2'b01, 1, p * 16) : (j == 1) ? mk(2'b00, 0, p * 16 + 1) : mk(2'b10, 0, p * 16 + 2);
      if (j == 0) chk(log_f[1][k] == e, "R6", int'(log_f[1][k]), int'(e));
      else        chk(log_f[1][k] == e, "R3", int'(log_f[1][k]), int'(e));
    end

    // R8/R9: output 2 stalled, two heads want it, another packet goes to output 3.
    do_reset();
    src_q[0][0] = mk(2'b01, 2, 8'hA0);
    src_q[0][1] = mk(2'b00, 0, 8'hA1);
    src_q[0][2] = mk(2'b10, 0, 8'hA2);
    src_len[0] = 3;
    src_q[2][0] = mk(2'b11, 6, 8'hC0);
    src_len[2] = 1;
    src_q[1][0] = mk(2'b01, 3, 8'hB0);
    src_q[1][1] = mk(2'b00, 0, 8'hB1);
    src_q[1][2] = mk(2'b10, 0, 8'hB2);
    src_len[1] = 3;
    rdy_mask = 4'b1011;
    repeat (6) step();
    chk(src_idx[0] + int'(hs_in[0]) == 1, "R8", src_idx[0] + int'(hs_in[0]), 1);
    chk(in_ready[0] == 1'b0, "R8", int'(in_ready[0]), 0);
    chk(log_n[2] == 0, "R9", log_n[2], 0);
    chk(log_n[3] == 3, "R9", log_n[3], 3);
    chk(out_valid[2] && out_flit[2] == mk(2'b01, 2, 8'hA0), "R4", int'(out_flit[2]), int'(mk(2'b01, 2, 8'hA0)));
    rdy_mask = '1;
    repeat (8) step();
    chk(log_n[2] == 4, "R4", log_n[2], 4);
    chk(log_f[2][0] == mk(2'b01, 2, 8'hA0), "R3", int'(log_f[2][0]), int'(mk(2'b01, 2, 8'hA0)));
    chk(log_f[2][1] == mk(2'b00, 0, 8'hA1), "R3", int'(log_f[2][1]), int'(mk(2'b00, 0, 8'hA1)));
    chk(log_f[2][2] == mk(2'b10, 0, 8'hA2), "R3", int'(log_f[2][2]), int'(mk(2'b10, 0, 8'hA2)));
    chk(log_f[2][3] == mk(2'b11, 6, 8'hC0), "R4", int'(log_f[2][3]), int'(mk(2'b11, 6, 8'hC0)));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule